// File: doc/BRIEF.md
# UART Interrupt Source Identifier

This block ranks the interrupt causes of a UART and reports the most urgent enabled one as a four-bit code that a host reads from a read-only identification register. It also owns the rules that retire each cause. Receive line errors, receive data and the character timeout come in as levels held by the receive path. The transmit request and the modem-status change are events that the block latches itself.

The transmit request has two possible triggers, and `fifo_mode` picks between them. With FIFOs off, the request fires when the holding register becomes empty. With FIFOs on, it fires when the transmit FIFO drops to half full or less. The request is retired when transmit data is written. It is also retired when the identification register is read while the request is the code on show. A read that shows a higher-priority code leaves the request alone. The modem-status event is retired only by a read of the modem status register.

Top module: `uart_int_ident`

## Requirements
- R1: After reset the code is 4'b0001, `int_pend` is 0 and `irq` is 0. The code keeps this value whenever no enabled source is pending.
- R2: An enabled line-error level (`line_err`) gives code 4'b0110. This code wins over every other source.
- R3: An enabled receive-ready level (`rx_ready`) gives code 4'b0100. It ranks below line error and above every other source.
- R4: The character-timeout level (`rx_stale`) gives code 4'b1100. It is enabled by `en_rx` and only counts in FIFO mode. It ranks below receive-ready and above the transmit request.
- R5: The transmit request is latched one clock after a rising edge of the selected trigger. With `fifo_mode`=0 the trigger is `thr_empty`; with `fifo_mode`=1 it is `txf_low`. The trigger that is not selected has no effect. While the trigger stays high, the request does not re-arm.
- R6: The transmit request gives code 4'b0010 and ranks above modem status. An `iir_rd` strobe clears it one clock later, but only if the code shown during that strobe was 4'b0010.
- R7: A `thr_wr` strobe clears the transmit request one clock later.
- R8: A `modem_delta` pulse latches a modem-status event, which gives code 4'b0000. Only an `msr_rd` strobe clears it; `iir_rd` does not.
- R9: A disabled source changes neither the code nor `irq`. Its latched event is kept, so it appears once the source is enabled.
- R10: `irq` is 1 exactly when some enabled source is pending, and `int_pend` equals the inverse of code bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_mode | input | 1 | 1 = FIFOs enabled |
| en_line | input | 1 | Enable for line-error source |
| en_rx | input | 1 | Enable for receive-ready and timeout sources |
| en_tx | input | 1 | Enable for transmit request |
| en_modem | input | 1 | Enable for modem-status source |
| line_err | input | 1 | Receive line error level |
| rx_ready | input | 1 | Receive data / trigger level reached |
| rx_stale | input | 1 | Character timeout level |
| thr_empty | input | 1 | Holding register empty (non-FIFO trigger) |
| txf_low | input | 1 | Transmit FIFO at most half full (FIFO trigger) |
| modem_delta | input | 1 | Pulse: a modem input changed |
| iir_rd | input | 1 | Strobe: identification register read |
| thr_wr | input | 1 | Strobe: transmit data write |
| msr_rd | input | 1 | Strobe: modem status read |
| iir_id | output | 4 | Identification code |
| int_pend | output | 1 | An enabled source is pending |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach is a read of the identification register while the transmit request is latched but hidden behind a higher source. If that read cleared the request anyway, the next code would simply be wrong, and nothing else would show it. The bench raises the transmit trigger first and then holds `line_err` high. It strobes `iir_rd` while code 4'b0110 is on show, then drops the line error and expects 4'b0010 to appear. A second hard case is the request failing to re-arm on a trigger that stays high. The bench covers it by reading the code once more after the clear, with the trigger still asserted.

// File: rtl/uart_iid_pkg.sv
// Shared codes for the UART interrupt identifier.
// Assumes a four-bit code; bit 0 high means nothing pending.
package uart_iid_pkg;
    localparam int ID_W = 4;
    typedef enum logic [ID_W-1:0] {
        ID_LINE  = 4'b0110,
        ID_RXRDY = 4'b0100,
        ID_STALE = 4'b1100,
        ID_TXREQ = 4'b0010,
        ID_MODEM = 4'b0000,
        ID_IDLE  = 4'b0001
    } iid_code_t;
endpackage

// File: rtl/uart_iid_evt.sv
// Event latch for one interrupt source.
// With EDGE_SET=1 it arms on a rising edge of cond; otherwise on cond high.
// Assumes: when set and clear meet in one cycle, set wins (a fresh event).
module uart_iid_evt #(
    parameter bit EDGE_SET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic clr,
    output logic set_now,
    output logic pend
);
    generate
        if (EDGE_SET) begin : g_edge
            logic cond_q;
            // remember the previous trigger level for edge detection
            always_ff @(posedge clk) begin
                if (!rst_n) cond_q <= 1'b0;
                else        cond_q <= cond;
            end
            assign set_now = cond & ~cond_q;
        end else begin : g_level
            assign set_now = cond;
        end
    endgenerate

    // hold the event until its clearing strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (set_now) pend <= 1'b1;
        else if (clr)     pend <= 1'b0;
    end

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_now |=> pend);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_now) |=> !pend);
endmodule

// File: rtl/uart_iid_prio.sv
// Priority encoder: picks the highest enabled pending source.
// Assumes the level inputs are already qualified by their enables.
module uart_iid_prio
    import uart_iid_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_line,
    input  logic       hit_rx,
    input  logic       hit_stale,
    input  logic       hit_tx,
    input  logic       hit_modem,
    output iid_code_t  code
);
    // fixed-priority selection, highest first
    always_comb begin
        if (hit_line)       code = ID_LINE;
        else if (hit_rx)    code = ID_RXRDY;
        else if (hit_stale) code = ID_STALE;
        else if (hit_tx)    code = ID_TXREQ;
        else if (hit_modem) code = ID_MODEM;
        else                code = ID_IDLE;
    end

    assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_line |-> code == ID_LINE);
    assert_rx_over_stale_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rx && !hit_line) |-> code == ID_RXRDY);
endmodule

// File: rtl/uart_int_ident.sv
// UART interrupt identifier top.
// Ranks the sources, latches the transmit and modem events, and applies
// the clear-on-event rules. Assumes strobes are single-cycle and
// synchronous to clk.
module uart_int_ident
    import uart_iid_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fifo_mode,
    input  logic            en_line,
    input  logic            en_rx,
    input  logic            en_tx,
    input  logic            en_modem,
    input  logic            line_err,
    input  logic            rx_ready,
    input  logic            rx_stale,
    input  logic            thr_empty,
    input  logic            txf_low,
    input  logic            modem_delta,
    input  logic            iir_rd,
    input  logic            thr_wr,
    input  logic            msr_rd,
    output logic [ID_W-1:0] iir_id,
    output logic            int_pend,
    output logic            irq
);
    iid_code_t code;
    logic tx_trig, tx_clr, tx_set, tx_pend;
    logic ms_set, ms_pend;
    logic hit_line, hit_rx, hit_stale, hit_tx, hit_modem;

    // transmit trigger depends on FIFO mode
    assign tx_trig = fifo_mode ? txf_low : thr_empty;
    // a read clears only when the transmit code is the one presented
    assign tx_clr  = thr_wr | (iir_rd & (code == ID_TXREQ));

    uart_iid_evt #(.EDGE_SET(1'b1)) i_tx_evt (
        .clk(clk), .rst_n(rst_n), .cond(tx_trig), .clr(tx_clr),
        .set_now(tx_set), .pend(tx_pend));

    uart_iid_evt #(.EDGE_SET(1'b0)) i_ms_evt (
        .clk(clk), .rst_n(rst_n), .cond(modem_delta), .clr(msr_rd),
        .set_now(ms_set), .pend(ms_pend));

    // qualify each source with its enable
    assign hit_line  = en_line  & line_err;
    assign hit_rx    = en_rx    & rx_ready;
    assign hit_stale = en_rx    & fifo_mode & rx_stale;
    assign hit_tx    = en_tx    & tx_pend;
    assign hit_modem = en_modem & ms_pend;

    uart_iid_prio i_prio (
        .clk(clk), .rst_n(rst_n),
        .hit_line(hit_line), .hit_rx(hit_rx), .hit_stale(hit_stale),
        .hit_tx(hit_tx), .hit_modem(hit_modem), .code(code));

    assign iir_id   = code;
    assign int_pend = ~code[0];
    assign irq      = hit_line | hit_rx | hit_stale | hit_tx | hit_modem;

    assert_irq_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == int_pend);
    assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_id == 4'b0010 && !tx_set) |=> !tx_pend);
    assert_hidden_read_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pend && iir_rd && iir_id != 4'b0010 && !thr_wr) |=> tx_pend);
    assert_modem_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !ms_set) |=> !ms_pend);
    assert_modem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_pend && !msr_rd) |=> ms_pend);
endmodule

// File: tb/test_uart_int_ident.sv
module test_uart_int_ident;
    logic clk = 1'b0;
    logic rst_n;
    logic fifo_mode, en_line, en_rx, en_tx, en_modem;
    logic line_err, rx_ready, rx_stale, thr_empty, txf_low, modem_delta;
    logic iir_rd, thr_wr, msr_rd;
    logic [3:0] iir_id;
    logic int_pend, irq;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    uart_int_ident i_uart_int_ident (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
        .en_line(en_line), .en_rx(en_rx), .en_tx(en_tx), .en_modem(en_modem),
        .line_err(line_err), .rx_ready(rx_ready), .rx_stale(rx_stale),
        .thr_empty(thr_empty), .txf_low(txf_low), .modem_delta(modem_delta),
        .iir_rd(iir_rd), .thr_wr(thr_wr), .msr_rd(msr_rd),
        .iir_id(iir_id), .int_pend(int_pend), .irq(irq));

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {fifo_mode, line_err, rx_ready, rx_stale, thr_empty, txf_low} = '0;
        {modem_delta, iir_rd, thr_wr, msr_rd} = '0;
        {en_line, en_rx, en_tx, en_modem} = 4'b1111;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 id", iir_id, 4'b0001);
        check("R1 pend", {3'b0, int_pend}, 4'd0);
        check("R1 irq", {3'b0, irq}, 4'd0);
    endtask

    task automatic t_priority();
        do_reset();
        fifo_mode = 1'b1;
        modem_delta = 1'b1; step(); modem_delta = 1'b0; step();
        check("R8 modem code", iir_id, 4'b0000);
        check("R10 irq", {3'b0, irq}, 4'd1);
        check("R10 pend", {3'b0, int_pend}, 4'd1);
        txf_low = 1'b1; step();
        check("R6 tx over modem", iir_id, 4'b0010);
        rx_stale = 1'b1; #1;
        check("R4 timeout over tx", iir_id, 4'b1100);
        rx_ready = 1'b1; #1;
        check("R3 rx over timeout", iir_id, 4'b0100);
        line_err = 1'b1; #1;
        check("R2 line first", iir_id, 4'b0110);
        line_err = 1'b0; rx_ready = 1'b0; rx_stale = 1'b0; #1;
        check("R6 tx back", iir_id, 4'b0010);
    endtask

    task automatic t_stale_nonfifo();
        do_reset();
        rx_stale = 1'b1; #1;
        check("R4 ignored non-FIFO", iir_id, 4'b0001);
        step();
        check("R4 irq non-FIFO", {3'b0, irq}, 4'd0);
    endtask

    task automatic t_tx_nonfifo();
        do_reset();
        txf_low = 1'b1; step();
        check("R5 other trigger ignored", iir_id, 4'b0001);
        thr_empty = 1'b1; step();
        check("R5 empty sets", iir_id, 4'b0010);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        check("R6 read clears", iir_id, 4'b0001);
        step(); step();
        check("R5 no re-arm", iir_id, 4'b0001);
        thr_empty = 1'b0; thr_wr = 1'b1; step(); thr_wr = 1'b0;
        thr_empty = 1'b1; step();
        check("R5 re-arm on edge", iir_id, 4'b0010);
        thr_wr = 1'b1; step(); thr_wr = 1'b0;
        check("R7 write clears", iir_id, 4'b0001);
    endtask

    task automatic t_tx_fifo();
        do_reset();
        fifo_mode = 1'b1;
        thr_empty = 1'b1; step();
        check("R5 FIFO ignores empty", iir_id, 4'b0001);
        txf_low = 1'b1; step();
        check("R5 FIFO low sets", iir_id, 4'b0010);
    endtask

    task automatic t_hidden_read();
        do_reset();
        thr_empty = 1'b1; step();
        line_err = 1'b1; #1;
        check("R2 hides tx", iir_id, 4'b0110);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        line_err = 1'b0; #1;
        check("R6 hidden read keeps tx", iir_id, 4'b0010);
    endtask

    task automatic t_modem();
        do_reset();
        modem_delta = 1'b1; step(); modem_delta = 1'b0; step();
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        check("R8 iir read keeps modem", iir_id, 4'b0000);
        msr_rd = 1'b1; step(); msr_rd = 1'b0;
        check("R8 msr read clears", iir_id, 4'b0001);
    endtask

    task automatic t_disabled();
        do_reset();
        en_modem = 1'b0;
        modem_delta = 1'b1; step(); modem_delta = 1'b0; step();
        check("R9 disabled code", iir_id, 4'b0001);
        check("R9 disabled irq", {3'b0, irq}, 4'd0);
        en_line = 1'b0; line_err = 1'b1; #1;
        check("R9 line disabled", iir_id, 4'b0001);
        en_modem = 1'b1; #1;
        check("R9 kept event shows", iir_id, 4'b0000);
        check("R10 irq on enable", {3'b0, irq}, 4'd1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_priority();
                t_stale_nonfifo();
                t_tx_nonfifo();
                t_tx_fifo();
                t_hidden_read();
                t_modem();
                t_disabled();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule